// File: doc/BRIEF.md
# Indexed Codec Control Register File

This block is the register front end of an audio codec on a simple 32-bit memory-mapped bus. The bus offset selects one of sixteen direct 32-bit words. Direct word 0 acts as an index into a second, narrower space of thirty-two 8-bit codec registers. Direct word 1 is a data window that reads and writes whichever indirect register that index currently names.

Each indirect register follows its own access rule. One can be written but always reads as zero. Two ignore writes. One always carries a fixed version pattern, and only a single bit of it can be written. On the direct side, one word ignores writes. A control word wipes the whole register state when its low bit is written as one, and keeps only a masked copy of the value that was written. The interrupt output exists for pin compatibility and is held low. Audio data, DMA and interrupt sources are not part of this block.

Top module: `codec_regs`

## Requirements
- R1: The direct word index is request address bits [5:2]. Address bits [1:0] and all bits above bit 5 are ignored.
- R2: A read request (valid high, write low) gives rsp_valid high with the read word on rsp_rdata on the next clock. Write or idle cycles give rsp_valid low on the next clock, and rsp_rdata keeps its previous value.
- R3: Direct words 0, 3 and 5 to 15 store the full 32-bit write data and read it back unchanged.
- R4: The indirect index is bits [4:0] of direct word 0. A write to direct word 1 stores write data bits [7:0] in the selected indirect register. A read of direct word 1 returns that register zero-extended to 32 bits.
- R5: Indirect register 3 always reads as zero through the window, whatever was written to it.
- R6: Writes to indirect registers 11 and 25 have no effect: register 11 reads 0x00 and register 25 reads 0xA0.
- R7: A write of value v to indirect register 12 stores (v & 0x40) | 0x8A.
- R8: Direct word 2 ignores writes and always reads zero.
- R9: A write to direct word 4 stores the write data masked to bits [6:0]. When bit 0 of that data is 1, every other direct and indirect register returns to its reset value at the end of that cycle, and direct word 4 keeps the masked value.
- R10: After rst_n is released, all direct words read zero, indirect registers read zero except register 12 (0x8A) and register 25 (0xA0), and rsp_valid is low.
- R11: irq_o is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, held low |

## Verification
Every read result appears exactly one clock after its request: the request is sampled on a rising edge, and the response register updates on that same edge. The bench therefore drives on falling edges and queues the expected word when it issues a read. Its monitor compares on the next falling edge whenever rsp_valid is high. Writes, including the soft reset, take effect on the edge that samples them. A read issued in the very next cycle already sees the new state, so sequences of writes followed by reads have no idle gaps.

// File: rtl/codec_regs_pkg.sv
package codec_regs_pkg;

   typedef enum logic [1:0] {
      IK_PLAIN   = 2'd0,
      IK_WRONLY  = 2'd1,
      IK_RDONLY  = 2'd2,
      IK_VERSION = 2'd3
   } ind_kind_e;

   typedef enum logic [1:0] {
      DK_PLAIN   = 2'd0,
      DK_WINDOW  = 2'd1,
      DK_RDONLY  = 2'd2,
      DK_CONTROL = 2'd3
   } dir_kind_e;

   function automatic ind_kind_e ind_kind(input int idx, input int wo_idx,
                                          input int ro_a, input int ro_b,
                                          input int ver_idx);
      if (idx == wo_idx)                   return IK_WRONLY;
      else if (idx == ro_a || idx == ro_b) return IK_RDONLY;
      else if (idx == ver_idx)             return IK_VERSION;
      else                                 return IK_PLAIN;
   endfunction

   function automatic dir_kind_e dir_kind(input int idx, input int win_idx,
                                          input int ro_idx, input int ctl_idx);
      if (idx == win_idx)      return DK_WINDOW;
      else if (idx == ro_idx)  return DK_RDONLY;
      else if (idx == ctl_idx) return DK_CONTROL;
      else                     return DK_PLAIN;
   endfunction

endpackage

// File: rtl/codec_addr_dec.sv
module codec_addr_dec #(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int WIN_BITS  = 6,
   parameter int WIN_IDX   = 1,
   parameter int CTL_IDX   = 4,
   parameter int SRST_BIT  = 0,
   localparam int DIR_IDX_W = WIN_BITS - 2
) (
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic [DIR_IDX_W-1:0] dir_idx,
   output logic                 rd_req,
   output logic                 wr_dir,
   output logic                 wr_win,
   output logic                 win_sel,
   output logic                 soft_rst
);

   logic wr_any;

   always_comb begin
      dir_idx  = req_addr[WIN_BITS-1:2];
      rd_req   = req_valid && !req_write;
      wr_any   = req_valid && req_write;
      win_sel  = (dir_idx == DIR_IDX_W'(WIN_IDX));
      wr_win   = wr_any && win_sel;
      wr_dir   = wr_any && !win_sel;
      soft_rst = wr_any && (dir_idx == DIR_IDX_W'(CTL_IDX)) && req_wdata[SRST_BIT];
   end

endmodule

// File: rtl/codec_dir_bank.sv
module codec_dir_bank
   import codec_regs_pkg::*;
#(
   parameter int              DATA_W   = 32,
   parameter int              DIR_N    = 16,
   parameter int              WIN_IDX  = 1,
   parameter int              RO_IDX   = 2,
   parameter int              CTL_IDX  = 4,
   parameter int              PTR_IDX  = 0,
   parameter logic [DATA_W-1:0] CTL_MASK = 32'h0000_007F,
   localparam int             DIR_IDX_W = $clog2(DIR_N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 wr_en,
   input  logic [DIR_IDX_W-1:0] wr_idx,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [DIR_IDX_W-1:0] rd_idx,
   output logic [DATA_W-1:0]    rd_word,
   output logic [DATA_W-1:0]    ptr_word
);

   logic [DATA_W-1:0] view [DIR_N];

   for (genvar i = 0; i < DIR_N; i++) begin : g_word
      localparam dir_kind_e KIND = dir_kind(i, WIN_IDX, RO_IDX, CTL_IDX);
      logic hit;
      assign hit = wr_en && (wr_idx == DIR_IDX_W'(i));

      if (KIND == DK_WINDOW || KIND == DK_RDONLY) begin : g_const
         // No storage: window reads are diverted, read-only word is zero.
         assign view[i] = '0;
      end else if (KIND == DK_CONTROL) begin : g_ctl
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (hit)
               q <= wr_data & CTL_MASK;
         end
         assign view[i] = q;
      end else begin : g_plain
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (soft_rst)
               q <= '0;
            else if (hit)
               q <= wr_data;
         end
         assign view[i] = q;
      end
   end

   assign rd_word  = view[rd_idx];
   assign ptr_word = view[PTR_IDX];

endmodule

// File: rtl/codec_ind_bank.sv
module codec_ind_bank
   import codec_regs_pkg::*;
#(
   parameter int               IND_W    = 8,
   parameter int               IND_N    = 32,
   parameter int               WO_IDX   = 3,
   parameter int               RO_A     = 11,
   parameter int               RO_B     = 25,
   parameter int               VER_IDX  = 12,
   parameter logic [IND_W-1:0] VER_BASE = 8'h8A,
   parameter logic [IND_W-1:0] VER_KEEP = 8'h40,
   parameter int               ID_IDX   = 25,
   parameter logic [IND_W-1:0] ID_CODE  = 8'hA0,
   localparam int              IDX_W    = $clog2(IND_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [IND_W-1:0] wr_byte,
   output logic [IND_W-1:0] rd_byte
);

   logic [IND_W-1:0] view [IND_N];

   for (genvar i = 0; i < IND_N; i++) begin : g_cell
      localparam ind_kind_e KIND = ind_kind(i, WO_IDX, RO_A, RO_B, VER_IDX);
      localparam logic [IND_W-1:0] RST_VAL =
         (i == VER_IDX) ? VER_BASE : ((i == ID_IDX) ? ID_CODE : '0);
      logic hit;
      assign hit = wr_en && (idx == IDX_W'(i));

      if (KIND == IK_RDONLY) begin : g_ro
         assign view[i] = RST_VAL;
      end else begin : g_rw
         logic [IND_W-1:0] q;
         logic [IND_W-1:0] nxt;
         if (KIND == IK_VERSION) begin : g_ver
            assign nxt = (wr_byte & VER_KEEP) | VER_BASE;
         end else begin : g_std
            assign nxt = wr_byte;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= RST_VAL;
            else if (soft_rst)
               q <= RST_VAL;
            else if (hit)
               q <= nxt;
         end
         if (KIND == IK_WRONLY) begin : g_hide
            // Value is kept internally but never returned on reads.
            logic unused_q;
            assign unused_q = ^q;
            assign view[i]  = '0;
         end else begin : g_show
            assign view[i] = q;
         end
      end
   end

   assign rd_byte = view[idx];

endmodule

// File: rtl/codec_regs.sv
module codec_regs
   import codec_regs_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WIN_BITS = 6,
   parameter int DIR_N    = 16,
   parameter int IND_W    = 8,
   parameter int IND_N    = 32,
   parameter int PTR_IDX  = 0,
   parameter int WIN_IDX  = 1,
   parameter int RO_IDX   = 2,
   parameter int CTL_IDX  = 4,
   parameter int SRST_BIT = 0,
   parameter logic [DATA_W-1:0] CTL_MASK = 32'h0000_007F,
   parameter int WO_IDX   = 3,
   parameter int RO_A     = 11,
   parameter int RO_B     = 25,
   parameter int VER_IDX  = 12,
   parameter logic [IND_W-1:0] VER_BASE = 8'h8A,
   parameter logic [IND_W-1:0] VER_KEEP = 8'h40,
   parameter int ID_IDX   = 25,
   parameter logic [IND_W-1:0] ID_CODE  = 8'hA0,
   localparam int DIR_IDX_W = WIN_BITS - 2,
   localparam int IDX_W     = $clog2(IND_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              irq_o
);

   // Elaboration-time parameter checks
   if (DIR_N != (1 << DIR_IDX_W)) begin : g_bad_dir
      $error("DIR_N must equal 2**(WIN_BITS-2)");
   end
   if (IND_N != (1 << IDX_W)) begin : g_bad_ind
      $error("IND_N must be a power of two");
   end
   if (DATA_W < IND_W || DATA_W < IDX_W) begin : g_bad_w
      $error("DATA_W too narrow for indirect data or index");
   end
   if (ADDR_W < WIN_BITS) begin : g_bad_a
      $error("ADDR_W must cover the decoded window");
   end
   if (WO_IDX >= IND_N || RO_A >= IND_N || RO_B >= IND_N ||
       VER_IDX >= IND_N || ID_IDX >= IND_N) begin : g_bad_iidx
      $error("indirect special index out of range");
   end
   if (WIN_IDX >= DIR_N || RO_IDX >= DIR_N || CTL_IDX >= DIR_N ||
       PTR_IDX >= DIR_N || SRST_BIT >= DATA_W) begin : g_bad_didx
      $error("direct special index out of range");
   end

   logic [DIR_IDX_W-1:0] dir_idx;
   logic                 rd_req;
   logic                 wr_dir;
   logic                 wr_win;
   logic                 win_sel;
   logic                 soft_rst;
   logic [DATA_W-1:0]    dir_word;
   logic [DATA_W-1:0]    ptr_word;
   logic [IDX_W-1:0]     ind_ptr;
   logic [IND_W-1:0]     ind_byte;
   logic [DATA_W-1:0]    rd_mux;

   codec_addr_dec #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .WIN_BITS (WIN_BITS),
      .WIN_IDX  (WIN_IDX),
      .CTL_IDX  (CTL_IDX),
      .SRST_BIT (SRST_BIT)
   ) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dir_idx   (dir_idx),
      .rd_req    (rd_req),
      .wr_dir    (wr_dir),
      .wr_win    (wr_win),
      .win_sel   (win_sel),
      .soft_rst  (soft_rst)
   );

   codec_dir_bank #(
      .DATA_W   (DATA_W),
      .DIR_N    (DIR_N),
      .WIN_IDX  (WIN_IDX),
      .RO_IDX   (RO_IDX),
      .CTL_IDX  (CTL_IDX),
      .PTR_IDX  (PTR_IDX),
      .CTL_MASK (CTL_MASK)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (wr_dir),
      .wr_idx   (dir_idx),
      .wr_data  (req_wdata),
      .rd_idx   (dir_idx),
      .rd_word  (dir_word),
      .ptr_word (ptr_word)
   );

   assign ind_ptr = ptr_word[IDX_W-1:0];

   codec_ind_bank #(
      .IND_W    (IND_W),
      .IND_N    (IND_N),
      .WO_IDX   (WO_IDX),
      .RO_A     (RO_A),
      .RO_B     (RO_B),
      .VER_IDX  (VER_IDX),
      .VER_BASE (VER_BASE),
      .VER_KEEP (VER_KEEP),
      .ID_IDX   (ID_IDX),
      .ID_CODE  (ID_CODE)
   ) u_ind (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .wr_en    (wr_win),
      .idx      (ind_ptr),
      .wr_byte  (req_wdata[IND_W-1:0]),
      .rd_byte  (ind_byte)
   );

   always_comb begin
      if (win_sel)
         rd_mux = {{(DATA_W-IND_W){1'b0}}, ind_byte};
      else
         rd_mux = dir_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_req;
         if (rd_req)
            rsp_rdata <= rd_mux;
      end
   end

   assign irq_o = 1'b0;

endmodule

// File: rtl/codec_regs_chk.sv
module codec_regs_chk #(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int WIN_BITS = 6,
   parameter int IND_W    = 8,
   parameter int IDX_W    = 5,
   parameter int WIN_IDX  = 1,
   parameter int RO_IDX   = 2,
   parameter int CTL_IDX  = 4,
   parameter int SRST_BIT = 0,
   parameter int WO_IDX   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic [DATA_W-1:0] req_wdata,
   input logic              rsp_valid,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              irq_o,
   input logic [IDX_W-1:0]  ind_ptr
);

   logic                is_rd;
   logic                is_wr;
   logic [WIN_BITS-3:0] widx;

   assign is_rd = req_valid && !req_write;
   assign is_wr = req_valid && req_write;
   assign widx  = req_addr[WIN_BITS-1:2];

   // R2
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);

   // R2
   no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rsp_valid);

   // R2
   hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> $stable(rsp_rdata));

   // R8
   ro_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && widx == (WIN_BITS-2)'(RO_IDX)) |=> rsp_rdata == '0);

   // R5
   wo_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && widx == (WIN_BITS-2)'(WIN_IDX) && ind_ptr == IDX_W'(WO_IDX))
      |=> rsp_rdata == '0);

   // R4
   zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && widx == (WIN_BITS-2)'(WIN_IDX)) |=> rsp_rdata[DATA_W-1:IND_W] == '0);

   // R9
   srst_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && widx == (WIN_BITS-2)'(CTL_IDX) && req_wdata[SRST_BIT]) |=> ind_ptr == '0);

   // R11
   irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_o);

endmodule

bind codec_regs codec_regs_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WIN_BITS (WIN_BITS),
   .IND_W    (IND_W),
   .IDX_W    (IDX_W),
   .WIN_IDX  (WIN_IDX),
   .RO_IDX   (RO_IDX),
   .CTL_IDX  (CTL_IDX),
   .SRST_BIT (SRST_BIT),
   .WO_IDX   (WO_IDX)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_write (req_write),
   .req_addr  (req_addr),
   .req_wdata (req_wdata),
   .rsp_valid (rsp_valid),
   .rsp_rdata (rsp_rdata),
   .irq_o     (irq_o),
   .ind_ptr   (ind_ptr)
);

// File: tb/codec_regs_test.sv
module codec_regs_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        irq_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10ns clk = ~clk;

   codec_regs uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rsp_valid (rsp_valid),
      .rsp_rdata (rsp_rdata),
      .irq_o     (irq_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   // Monitor: pops expected reads one cycle after they were issued
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rsp_valid) begin
            if (exp_q.size() == 0) begin
               check("R2 unexpected response", 32'h1, 32'h0);
            end else begin
               check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
         end
      end
   end

   task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b1;
      req_addr  = a;
      req_wdata = d;
   endtask

   task automatic bus_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      req_valid = 1'b1;
      req_write = 1'b0;
      req_addr  = a;
      req_wdata = 32'hFFFF_FFFF;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   task automatic bus_idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         req_valid = 1'b0;
         req_write = 1'b0;
      end
   endtask

   function automatic logic [31:0] dw(input int k);
      return 32'(k * 4);
   endfunction

   task automatic ind_write(input int idx, input logic [31:0] d);
      bus_write(dw(0), 32'(idx));
      bus_write(dw(1), d);
   endtask

   task automatic ind_read(input int idx, input logic [31:0] exp, input string tag);
      bus_write(dw(0), 32'(idx));
      bus_read(dw(1), exp, tag);
   endtask

   initial begin
      bus_idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state at the ports
      check("R10 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
      check("R10 rsp_rdata after reset", rsp_rdata, 32'h0);
      check("R11 irq after reset", {31'b0, irq_o}, 32'h0);

      // R10 reset values
      bus_read(dw(0), 32'h0, "R10 word0");
      bus_read(dw(5), 32'h0, "R10 word5");
      bus_read(dw(1), 32'h0, "R10 ind0");
      ind_read(12, 32'h8A, "R10 ind12");
      ind_read(25, 32'hA0, "R10 ind25");

      // R3 / R1 direct storage and decode
      bus_write(dw(5), 32'hDEAD_BEEF);
      bus_write(dw(15), 32'h1234_5678);
      bus_write(dw(3), 32'hA5A5_0F0F);
      bus_read(dw(5), 32'hDEAD_BEEF, "R3 word5");
      bus_read(dw(15), 32'h1234_5678, "R3 word15");
      bus_read(dw(3), 32'hA5A5_0F0F, "R3 word3");
      bus_read(32'hFFFF_FFC0 | dw(5) | 32'h3, 32'hDEAD_BEEF, "R1 high/low bits ignored");
      bus_write(32'h0000_1000 | dw(6) | 32'h2, 32'h0000_00C3);
      bus_read(dw(6), 32'h0000_00C3, "R1 aliased write");

      // R4 pointer and window
      bus_write(dw(0), 32'hFFFF_FFE7);
      bus_read(dw(0), 32'hFFFF_FFE7, "R3 word0 full width");
      bus_write(dw(1), 32'h0000_01A5);
      bus_read(dw(1), 32'h0000_00A5, "R4 ind7 low byte zero-extended");
      ind_write(0, 32'h3C);
      ind_read(0, 32'h3C, "R4 ind0");
      ind_read(7, 32'hA5, "R4 ind7 kept");

      // R5 write-only
      ind_write(3, 32'h55);
      ind_read(3, 32'h0, "R5 ind3 reads zero");

      // R6 read-only
      ind_write(11, 32'hFF);
      ind_read(11, 32'h0, "R6 ind11 unchanged");
      ind_write(25, 32'h00);
      ind_read(25, 32'hA0, "R6 ind25 unchanged");

      // R7 version register
      ind_write(12, 32'hFF);
      ind_read(12, 32'hCA, "R7 ind12 after 0xFF");
      ind_write(12, 32'h00);
      ind_read(12, 32'h8A, "R7 ind12 after 0x00");
      ind_write(12, 32'h40);
      ind_read(12, 32'hCA, "R7 ind12 after 0x40");

      // R8 read-only direct word
      bus_write(dw(2), 32'hFFFF_FFFF);
      bus_read(dw(2), 32'h0, "R8 word2");

      // R9 control word without reset bit
      bus_write(dw(4), 32'h0000_00FE);
      bus_read(dw(4), 32'h0000_007E, "R9 word4 masked");
      ind_read(7, 32'hA5, "R9 state kept without bit0");
      bus_read(dw(5), 32'hDEAD_BEEF, "R9 word5 kept");

      // R9 soft reset
      bus_write(dw(0), 32'h0000_0007);
      bus_write(dw(4), 32'hFFFF_FF83);
      bus_read(dw(4), 32'h0000_0003, "R9 word4 after soft reset");
      bus_read(dw(0), 32'h0, "R9 word0 cleared");
      bus_read(dw(1), 32'h0, "R9 ind0 cleared");
      bus_read(dw(15), 32'h0, "R9 word15 cleared");
      bus_read(dw(6), 32'h0, "R9 word6 cleared");
      ind_read(7, 32'h0, "R9 ind7 cleared");
      ind_read(12, 32'h8A, "R9 ind12 reloaded");
      ind_read(25, 32'hA0, "R9 ind25 reloaded");

      bus_idle(4);
      // R2 no stray responses and data holds
      check("R2 queue drained", 32'(exp_q.size()), 32'h0);
      check("R2 rsp_valid idle", {31'b0, rsp_valid}, 32'h0);
      check("R2 rdata held", rsp_rdata, 32'hA0);
      check("R11 irq at end", {31'b0, irq_o}, 32'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(20ns * 20000);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule